// File: doc/BRIEF.md
# SPI Slave Byte-Store Front End

This block is the serial front end of a small byte-addressed store of the kind found in clock and calendar peripherals. An external SPI master selects the block by driving an active-low chip select. The master sends one command byte, then any number of data bytes. The command byte carries the transfer direction and a starting location. Data then moves one byte at a time, and an internal location counter steps forward after every byte and wraps at the top of the space. The same framing applies to reads and writes.

All serial inputs are resynchronised into the system clock domain and their edges are detected there. This lets one edge rule serve a master whose serial clock idles low and one whose clock idles high. A power-fail input, synchronous to the system clock, ends any transfer at once and returns the location counter to zero. The block then ignores the serial bus until chip select is released. The store behind the interface is a plain byte array that clears on reset.

Top module: `spi_rf_top`

## Requirements
- R1: The block acts only while `spi_cs_n` is low. Serial clocks and data seen while it is high write nothing, and `spi_miso` reads 0 from a few system clocks after `spi_cs_n` rises.
- R2: Each byte moves most significant bit first, one bit per serial clock. `spi_mosi` is captured on the rising serial-clock edge, and `spi_miso` changes only after a falling edge, so it holds steady while the serial clock is high.
- R3: Masters whose serial clock idles low and masters whose serial clock idles high both work. A high serial clock at the moment chip select falls produces no capture.
- R4: The first byte after chip select falls is the command. Bit 7 = 1 selects write and bit 7 = 0 selects read. Bits 5..0 give the start location. Bit 6 is ignored, and data bytes sent by the master during a read change nothing.
- R5: In a write, each full data byte is stored at the current location, and the location then advances by one.
- R6: In a read, the byte at the current location is shifted out, starting on the falling edge that follows the last bit of the previous byte, and the location then advances by one.
- R7: The location counter wraps from 63 to 0 within a burst.
- R8: A data byte is committed only after all eight bits arrive. A partial byte cut off by chip select rising is discarded.
- R9: While `pwr_fail` is high, the transfer is aborted, the location counter is zero, no write occurs and `spi_miso` is 0. The bus stays ignored until chip select rises, even if `pwr_fail` falls first.
- R10: After reset, every location reads 0 and `spi_miso` is 0.
- R11: Each new chip-select period starts again with a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Active-low chip select from the master |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| pwr_fail | input | 1 | Power-fail abort and write lock, synchronous to clk |
| spi_miso | output | 1 | Serial data to the master, 0 when idle |

## Verification
The bench builds the block with its defaults: 6 address bits (64 locations), 8-bit data and 2 synchroniser stages. With 64 locations, the wrap from 63 to 0 falls inside a three-byte burst that starts at 62. The short synchroniser lets `spi_miso` settle about four system clocks after a falling serial edge, so a half period of eight system clocks gives each sample ample margin and still allows a mid-high stability check on every bit. Both serial clock idle levels are driven, for writes as well as reads.

// File: rtl/spi_rf_pkg.sv
`timescale 1ns/1ps
// Shared types for the SPI byte-store front end.
package spi_rf_pkg;
    // Framing phase: waiting for the command byte, or moving data bytes.
    typedef enum logic {
        PH_ADDR = 1'b0,
        PH_DATA = 1'b1
    } phase_e;
endpackage

// File: rtl/spi_rf_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for one asynchronous input.
// Assumes STAGES >= 2. The reset value is set per instance.
module spi_rf_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_rf_frame.sv
`timescale 1ns/1ps
// Serial-clock edge detection, bit counting and receive shifting.
// Assumes synchronised inputs and a power-of-two DATA_W.
// Selection is held off after a power fail until chip select rises.
module spi_rf_frame #(
    parameter int DATA_W = 8,
    parameter int BIT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic              pwr_fail,
    output logic              sel,
    output logic              rise,
    output logic              fall,
    output logic              byte_done,
    output logic [BIT_W-1:0]  bit_cnt,
    output logic [DATA_W-1:0] rx_byte
);
    logic              sck_q;
    logic              lock;
    logic [DATA_W-1:0] rx_sh;

    assign sel       = !cs_n_s && !lock && !pwr_fail;
    assign rise      = sel && sck_s && !sck_q;
    assign fall      = sel && !sck_s && sck_q;
    assign byte_done = rise && (bit_cnt == BIT_W'(DATA_W - 1));
    assign rx_byte   = {rx_sh[DATA_W-2:0], mosi_s};

    // Track the previous serial clock level, even while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    // Hold off the bus from a power fail until chip select is released.
    always_ff @(posedge clk) begin
        if (!rst_n)        lock <= 1'b0;
        else if (pwr_fail) lock <= 1'b1;
        else if (cs_n_s)   lock <= 1'b0;
    end

    // Count bits and shift in data. Both restart whenever deselected.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
        end else if (rise) begin
            bit_cnt <= bit_cnt + BIT_W'(1);
            rx_sh   <= rx_byte;
        end
    end
endmodule

// File: rtl/spi_rf_store.sv
`timescale 1ns/1ps
// Byte array with one synchronous write port and one combinational read port.
// Clears to zero on reset.
module spi_rf_store #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Clear on reset, otherwise write one byte when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/spi_rf_top.sv
`timescale 1ns/1ps
// SPI slave front end for a byte store.
// Command byte: MSB = write flag, low ADDR_W bits = start location,
// the bits between are ignored. Data bytes follow with auto-increment.
// Assumes DATA_W is a power of two, DATA_W >= ADDR_W + 2, and pwr_fail
// is synchronous to clk.
module spi_rf_top
    import spi_rf_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_mosi,
    input  logic pwr_fail,
    output logic spi_miso
);
    localparam int         BIT_W    = $clog2(DATA_W);
    localparam int         WR_BIT   = DATA_W - 1;
    localparam int         N_SYNC   = 3;
    localparam logic [2:0] SYNC_RST = 3'b001;  // cs_n idles high

    logic [N_SYNC-1:0] raw_in, syn_in;
    logic              cs_active, sck_rise, sck_fall, byte_done;
    logic [BIT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] rx_byte, tx_byte, rd_data;
    logic [ADDR_W-1:0] addr, rd_addr;
    logic              wr_mode, mem_we, miso_q;
    phase_e            phase;
    logic              addr_unused;

    assign raw_in = {spi_mosi, spi_sck, spi_cs_n};

    // One synchroniser for each serial input.
    for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
        spi_rf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST[g])) u_sync (
            .clk(clk), .rst_n(rst_n), .d(raw_in[g]), .q(syn_in[g])
        );
    end

    spi_rf_frame #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .cs_n_s(syn_in[0]), .sck_s(syn_in[1]), .mosi_s(syn_in[2]),
        .pwr_fail(pwr_fail),
        .sel(cs_active), .rise(sck_rise), .fall(sck_fall),
        .byte_done(byte_done), .bit_cnt(bit_cnt), .rx_byte(rx_byte)
    );

    assign mem_we      = byte_done && (phase == PH_DATA) && wr_mode;
    assign rd_addr     = (phase == PH_ADDR) ? rx_byte[ADDR_W-1:0]
                                            : addr + ADDR_W'(1);
    assign addr_unused = ^rx_byte[WR_BIT-1:ADDR_W];

    spi_rf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(mem_we),
        .waddr(addr), .wdata(rx_byte), .raddr(rd_addr), .rdata(rd_data)
    );

    // Framing: decode the command byte, step the location, preload read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_ADDR;
            wr_mode <= 1'b0;
            addr    <= '0;
            tx_byte <= '0;
        end else if (pwr_fail) begin
            phase   <= PH_ADDR;
            wr_mode <= 1'b0;
            addr    <= '0;
        end else if (!cs_active) begin
            phase   <= PH_ADDR;
        end else if (byte_done) begin
            tx_byte <= rd_data;
            if (phase == PH_ADDR) begin
                addr    <= rx_byte[ADDR_W-1:0];
                wr_mode <= rx_byte[WR_BIT];
                phase   <= PH_DATA;
            end else begin
                addr    <= addr + ADDR_W'(1);
            end
        end
    end

    // Present the next read bit after each falling serial-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_active) begin
            miso_q <= 1'b0;
        end else if (sck_fall) begin
            miso_q <= (phase == PH_DATA && !wr_mode) ? tx_byte[~bit_cnt] : 1'b0;
        end
    end

    assign spi_miso = miso_q && cs_active;
endmodule

// File: rtl/spi_rf_chk.sv
`timescale 1ns/1ps
// Assertion checker for spi_rf_top, attached by bind below.
module spi_rf_chk #(
    parameter int ADDR_W      = 6,
    parameter int BIT_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic              pwr_fail,
    input logic              spi_miso,
    input logic              cs_active,
    input logic              sck_rise,
    input logic [BIT_W-1:0]  bit_cnt,
    input logic [ADDR_W-1:0] addr,
    input logic              mem_we
);
    logic [3:0] hi_cnt;

    // Count the cycles chip select has been high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !spi_cs_n) hi_cnt <= '0;
        else if (hi_cnt != 4'hF) hi_cnt <= hi_cnt + 4'd1;
    end

    a_r1_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(hi_cnt) > SYNC_STAGES) |-> !spi_miso);

    a_r1_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |-> !mem_we);

    a_r2_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
        sck_rise |=> bit_cnt == BIT_W'($past(bit_cnt) + 1));

    // R7: the step also covers the wrap from the top location to zero.
    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> addr == ADDR_W'($past(addr) + 1));

    a_r8_write_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> sck_rise);

    a_r9_pf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (addr == '0) && !mem_we);

    a_r9_pf_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |-> !spi_miso);
endmodule

bind spi_rf_top spi_rf_chk #(
    .ADDR_W(ADDR_W), .BIT_W(BIT_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .pwr_fail(pwr_fail),
    .spi_miso(spi_miso), .cs_active(cs_active), .sck_rise(sck_rise),
    .bit_cnt(bit_cnt), .addr(addr), .mem_we(mem_we)
);

// File: tb/spi_rf_top_tb_top.sv
`timescale 1ns/1ps
// Directed bench for spi_rf_top: one task per scenario.
module spi_rf_top_tb_top;
    localparam int HALF = 8;  // system clocks per serial half period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic pf = 1'b0;
    logic miso;
    logic mode3 = 1'b0;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    spi_rf_top dut_i (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
        .spi_mosi(mosi), .pwr_fail(pf), .spi_miso(miso)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Shift nbits of tx MSB first; return what was sampled on miso.
    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            if (mode3) sck = 1'b0;
            mosi = tx[i];
            tick(HALF);
            rx[i] = miso;
            sck = 1'b1;
            tick(HALF);
            chk("R2 miso steady while clock high", {7'b0, miso}, {7'b0, rx[i]});
            if (!mode3) sck = 1'b0;
        end
    endtask

    task automatic frame_start();
        sck = mode3;
        tick(2);
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic frame_end();
        tick(HALF);
        cs_n = 1'b1;
        tick(2 * HALF);
    endtask

    task automatic wr_burst(input logic m3, input logic [7:0] cmd,
                            input logic [7:0] d [4], input int n);
        logic [7:0] rx;
        mode3 = m3;
        frame_start();
        xfer(cmd, 8, rx);
        for (int k = 0; k < n; k++) xfer(d[k], 8, rx);
        frame_end();
    endtask

    // Read burst; the master sends FF as data to show it is not written (R4).
    task automatic rd_check(input logic m3, input logic [7:0] cmd,
                            input logic [7:0] e [4], input int n, input string req);
        logic [7:0] rx;
        mode3 = m3;
        frame_start();
        xfer(cmd, 8, rx);
        for (int k = 0; k < n; k++) begin
            xfer(8'hFF, 8, rx);
            chk(req, rx, e[k]);
        end
        frame_end();
    endtask

    task automatic t_reset();
        chk("R10 miso after reset", {7'b0, miso}, 8'h00);
        rd_check(1'b0, 8'h00, '{8'h00, 8'h00, 8'h00, 8'h00}, 4, "R10 cleared store");
    endtask

    task automatic t_modes();
        wr_burst(1'b0, 8'h85, '{8'hA1, 8'hB2, 8'hC3, 8'h00}, 3);
        rd_check(1'b1, 8'h05, '{8'hA1, 8'hB2, 8'hC3, 8'h00}, 3, "R5 R6 R3 write idle-low read idle-high");
        wr_burst(1'b1, 8'h8C, '{8'h3C, 8'hC3, 8'h00, 8'h00}, 2);
        rd_check(1'b0, 8'h0C, '{8'h3C, 8'hC3, 8'h00, 8'h00}, 2, "R3 write idle-high read idle-low");
    endtask

    task automatic t_addr_bit6();
        wr_burst(1'b0, 8'hCA, '{8'h5A, 8'h00, 8'h00, 8'h00}, 1);
        rd_check(1'b0, 8'h0A, '{8'h5A, 8'h00, 8'h00, 8'h00}, 1, "R4 bit6 ignored on write");
        rd_check(1'b1, 8'h4A, '{8'h5A, 8'h00, 8'h00, 8'h00}, 1, "R4 bit6 ignored on read, read data not stored");
    endtask

    task automatic t_wrap();
        wr_burst(1'b0, 8'hBE, '{8'h11, 8'h22, 8'h33, 8'h00}, 3);
        rd_check(1'b0, 8'h3F, '{8'h22, 8'h33, 8'h00, 8'h00}, 2, "R7 wrap 63 to 0");
    endtask

    task automatic t_partial();
        logic [7:0] rx;
        wr_burst(1'b0, 8'h94, '{8'h77, 8'h00, 8'h00, 8'h00}, 1);
        mode3 = 1'b0;
        frame_start();
        xfer(8'h94, 8, rx);
        xfer(8'h00, 5, rx);
        frame_end();
        rd_check(1'b0, 8'h14, '{8'h77, 8'h00, 8'h00, 8'h00}, 2, "R8 partial byte discarded");
    endtask

    task automatic t_new_frame();
        wr_burst(1'b1, 8'h9E, '{8'h12, 8'h00, 8'h00, 8'h00}, 1);
        wr_burst(1'b1, 8'h9F, '{8'h34, 8'h00, 8'h00, 8'h00}, 1);
        rd_check(1'b0, 8'h1E, '{8'h12, 8'h34, 8'h00, 8'h00}, 2, "R11 second frame begins with command");
    endtask

    task automatic t_idle_ignored();
        logic [7:0] cmd = 8'hB2;
        logic [7:0] dat = 8'h99;
        sck = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            mosi = (i > 7) ? cmd[i-8] : dat[i];
            tick(HALF);
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
        chk("R1 miso idle with chip select high", {7'b0, miso}, 8'h00);
        rd_check(1'b0, 8'h32, '{8'h00, 8'h00, 8'h00, 8'h00}, 1, "R1 no write while deselected");
    endtask

    task automatic t_pwr_fail();
        logic [7:0] rx;
        wr_burst(1'b0, 8'hA8, '{8'h44, 8'h55, 8'h00, 8'h00}, 2);
        mode3 = 1'b0;
        frame_start();
        xfer(8'hA8, 8, rx);
        xfer(8'h00, 3, rx);
        pf = 1'b1;
        tick(4);
        pf = 1'b0;
        xfer(8'h00, 5, rx);
        xfer(8'hEE, 8, rx);
        frame_end();
        rd_check(1'b0, 8'h28, '{8'h44, 8'h55, 8'h00, 8'h00}, 2, "R9 no write after power fail");
        frame_start();
        xfer(8'h28, 8, rx);
        xfer(8'hFF, 3, rx);
        pf = 1'b1;
        tick(4);
        chk("R9 miso low during power fail", {7'b0, miso}, 8'h00);
        pf = 1'b0;
        xfer(8'hFF, 8, rx);
        chk("R9 bus ignored until deselect", rx, 8'h00);
        frame_end();
        rd_check(1'b1, 8'h28, '{8'h44, 8'h00, 8'h00, 8'h00}, 1, "R9 normal access after release");
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(4);
        t_reset();
        t_modes();
        t_addr_bit6();
        t_wrap();
        t_partial();
        t_new_frame();
        t_idle_ignored();
        t_pwr_fail();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule